// File: doc/BRIEF.md
# Isochronous Cycle Timer with Extended Bus Time

This block keeps the serial-bus cycle clock of a node. A 32-bit timer register advances on a 24.576 MHz tick enable and is split into three mixed-radix fields: a sub-cycle offset that counts 3072 ticks, a cycle number that counts 8000 cycles, and a 7-bit seconds field that wraps every 128 seconds. One second is therefore 3072 × 8000 ticks.

The 7-bit seconds field is stretched into a 32-bit bus time. A stored copy of the upper bus time bits carries its own copy of the seconds MSB. Whenever the live seconds MSB disagrees with that copy, the stored value steps by 0x40, so each half-turn of the seconds field is counted without any host polling. The host can load the timer, rewrite the upper bus time bits, and start the whole clock from a wall-clock seconds value. Two sticky event flags report a seconds wrap and a host rewrite of the timer. They drive a maskable interrupt.

Top module: `iso_cycle_clock`

## Requirements
- R1: After reset, cycle_time_o, bus_time_o and ev_flags_o are zero and irq_o is low.
- R2: cycle_time_o[11:0] is the offset. Each clock with tick_i and run_en_i both high adds one to it. A tick with run_en_i low changes nothing.
- R3: An advancing tick with the offset at 3071 or above sets the offset to 0 and carries into the cycle number (bits [24:12]). A carry into a cycle number at 7999 or above sets it to 0 and carries into the seconds field (bits [31:25]). Loaded values out of range therefore wrap on their next carry.
- R4: A carry into seconds equal to 127 sets seconds to 0 and sets event flag bit 0 (seconds wrap).
- R5: ct_wr_i loads all 32 bits of ct_wdata_i into the timer on the next edge. It takes precedence over a tick in the same cycle, and it sets event flag bit 1 (timer rewritten).
- R6: bus_time_o[31:7] comes from the stored upper bits and bus_time_o[6:0] equals the live seconds field. When the stored seconds-MSB copy differs from cycle_time_o[31], the stored value is advanced by 0x40, and the output already shows the advanced value.
- R7: bt_wr_i replaces the stored bits [31:7] with bt_wdata_i[31:7] and keeps the stored seconds-MSB copy as it stands after that cycle's carry.
- R8: init_i loads seconds with init_secs_i[6:0] and clears offset and cycle number. It loads the stored bus time with init_secs_i with its low 6 bits cleared. It takes precedence over ct_wr_i and bt_wr_i, and it sets no event flag.
- R9: Event flags stay set until a one is written on the matching bit of ev_clr_i. A flag being set and cleared in the same cycle ends set.
- R10: irq_o is high exactly when some flag is set while the matching ev_en_i bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 24.576 MHz tick enable |
| run_en_i | input | 1 | Timer run enable |
| init_i | input | 1 | Start strobe from wall-clock seconds |
| init_secs_i | input | 32 | Wall-clock seconds for init_i |
| ct_wr_i | input | 1 | Host write strobe for the timer |
| ct_wdata_i | input | 32 | Timer write value |
| bt_wr_i | input | 1 | Host write strobe for bus time |
| bt_wdata_i | input | 32 | Bus time write value (bits [31:7] used) |
| ev_clr_i | input | 2 | Write-one-to-clear for event flags |
| ev_en_i | input | 2 | Interrupt enable per event flag |
| cycle_time_o | output | 32 | Timer: seconds, cycle number, offset |
| bus_time_o | output | 32 | Extended bus time |
| ev_flags_o | output | 2 | Bit 0 seconds wrap, bit 1 timer rewritten |
| irq_o | output | 1 | Masked OR of the event flags |

## Verification
A host write to the timer and an advancing tick can land on the same edge. So can the raising of an event flag and its write-one-to-clear. The bench forces both collisions in directed steps: a write together with a tick while the timer sits at the last offset of the last cycle, and a write together with a clear of the rewrite flag. A long random run then mixes near-wrap loads, ticks, bus time writes and clears at random. Each edge is judged against a bench model that gives the write priority over the tick and lets a newly raised flag survive its clear.

// File: rtl/ictm_pkg.sv
package ictm_pkg;
  localparam int OFF_W = 12;
  localparam int CNT_W = 13;
  localparam int SEC_W = 7;
  localparam int CT_W  = OFF_W + CNT_W + SEC_W;
  localparam int BT_LO = SEC_W - 1;          // stored bus time keeps bits [31:6]
  localparam int BT_HW = CT_W - BT_LO;

  localparam int EV_N      = 2;
  localparam int EV_SEC64  = 0;
  localparam int EV_REWR   = 1;

  typedef struct packed {
    logic [SEC_W-1:0] sec;
    logic [CNT_W-1:0] cnt;
    logic [OFF_W-1:0] off;
  } cyc_time_t;
endpackage

// File: rtl/ictm_digit.sv
module ictm_digit #(
  parameter int W     = 12,
  parameter int LIMIT = 3072
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] q_q;
  logic         at_top;

  assign at_top  = (q_q >= TOP);
  assign carry_o = inc_i & at_top & ~load_i;
  assign q_o     = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_q <= '0;
    else if (load_i)  q_q <= load_val_i;
    else if (inc_i)   q_q <= at_top ? '0 : q_q + 1'b1;
  end

  a_r3_digit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i && !at_top |=> q_q == $past(q_q) + W'(1));
  a_r3_digit_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |=> q_q == '0);
  a_r5_digit_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_q == $past(load_val_i));
  a_r2_digit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !load_i |=> $stable(q_q));
endmodule

// File: rtl/ictm_bus_time.sv
module ictm_bus_time
  import ictm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic              init_i,
  input  logic [BT_HW-1:0]  init_hi_i,
  input  logic              wr_i,
  input  logic [BT_HW-2:0]  wdata_hi_i,
  output logic [CT_W-1:0]   bus_time_o
);
  logic [BT_HW-1:0] hi_q;
  logic [BT_HW-1:0] hi_adj;
  logic             msb_moved;

  // hi_q[0] mirrors the seconds MSB seen at the last update
  assign msb_moved  = hi_q[0] ^ sec_i[SEC_W-1];
  assign hi_adj     = hi_q + BT_HW'(msb_moved);
  assign bus_time_o = {hi_adj, {BT_LO{1'b0}}} | CT_W'(sec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hi_q <= '0;
    else if (init_i)  hi_q <= init_hi_i;
    else if (wr_i)    hi_q <= {wdata_hi_i, hi_adj[0]};
    else              hi_q <= hi_adj;
  end

  a_r6_low_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_time_o[SEC_W-1:0] == sec_i);
  a_r6_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_q[0] != sec_i[SEC_W-1]) && !wr_i && !init_i |=> hi_q == $past(hi_q) + 1'b1);
  a_r7_write_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !init_i |=> hi_q[BT_HW-1:1] == $past(wdata_hi_i));
  a_r8_init_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> hi_q == $past(init_hi_i));
endmodule

// File: rtl/ictm_events.sv
module ictm_events
  import ictm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_N-1:0] set_i,
  input  logic [EV_N-1:0] clr_i,
  input  logic [EV_N-1:0] en_i,
  output logic [EV_N-1:0] flags_o,
  output logic            irq_o
);
  logic [EV_N-1:0] flag_q;

  for (genvar i = 0; i < EV_N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;   // set beats clear
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & en_i);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |set_i |=> (flag_q & $past(set_i)) == $past(set_i));
  a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |flag_q |=> (flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i));
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i == '0 |=> (flag_q & ~$past(flag_q)) == '0);
endmodule

// File: rtl/iso_cycle_clock.sv
module iso_cycle_clock
  import ictm_pkg::*;
#(
  parameter int OFF_LIMIT = 3072,
  parameter int CNT_LIMIT = 8000,
  parameter int SEC_LIMIT = 1 << SEC_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_en_i,
  input  logic            init_i,
  input  logic [CT_W-1:0] init_secs_i,
  input  logic            ct_wr_i,
  input  logic [CT_W-1:0] ct_wdata_i,
  input  logic            bt_wr_i,
  input  logic [CT_W-1:0] bt_wdata_i,
  input  logic [EV_N-1:0] ev_clr_i,
  input  logic [EV_N-1:0] ev_en_i,
  output logic [CT_W-1:0] cycle_time_o,
  output logic [CT_W-1:0] bus_time_o,
  output logic [EV_N-1:0] ev_flags_o,
  output logic            irq_o
);
  cyc_time_t       ld_val, ct;
  logic            load, adv;
  logic            c_off, c_cnt, sec_wrap;
  logic [EV_N-1:0] ev_set;
  logic            unused_bt_lo;

  assign unused_bt_lo = ^bt_wdata_i[SEC_W-1:0];

  // init has priority over a host write, both over a tick
  assign load   = init_i | ct_wr_i;
  assign ld_val = init_i ? cyc_time_t'({init_secs_i[SEC_W-1:0], {(CNT_W+OFF_W){1'b0}}})
                         : cyc_time_t'(ct_wdata_i);
  assign adv    = tick_i & run_en_i;

  ictm_digit #(.W(OFF_W), .LIMIT(OFF_LIMIT)) i_off (
    .clk_i, .rst_ni, .inc_i(adv), .load_i(load), .load_val_i(ld_val.off),
    .q_o(ct.off), .carry_o(c_off));

  ictm_digit #(.W(CNT_W), .LIMIT(CNT_LIMIT)) i_cnt (
    .clk_i, .rst_ni, .inc_i(c_off), .load_i(load), .load_val_i(ld_val.cnt),
    .q_o(ct.cnt), .carry_o(c_cnt));

  ictm_digit #(.W(SEC_W), .LIMIT(SEC_LIMIT)) i_sec (
    .clk_i, .rst_ni, .inc_i(c_cnt), .load_i(load), .load_val_i(ld_val.sec),
    .q_o(ct.sec), .carry_o(sec_wrap));

  assign cycle_time_o = ct;

  ictm_bus_time i_bt (
    .clk_i, .rst_ni,
    .sec_i      (ct.sec),
    .init_i     (init_i),
    .init_hi_i  (init_secs_i[CT_W-1:BT_LO]),
    .wr_i       (bt_wr_i),
    .wdata_hi_i (bt_wdata_i[CT_W-1:SEC_W]),
    .bus_time_o (bus_time_o));

  always_comb begin
    ev_set           = '0;
    ev_set[EV_SEC64] = sec_wrap;
    ev_set[EV_REWR]  = ct_wr_i & ~init_i;
  end

  ictm_events i_ev (
    .clk_i, .rst_ni,
    .set_i   (ev_set),
    .clr_i   (ev_clr_i),
    .en_i    (ev_en_i),
    .flags_o (ev_flags_o),
    .irq_o   (irq_o));

  a_r4_wrap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_wrap |=> ev_flags_o[EV_SEC64] && cycle_time_o == '0);
  a_r5_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ct_wr_i && !init_i |=> cycle_time_o == $past(ct_wdata_i) && ev_flags_o[EV_REWR]);
  a_r2_run_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i && !load |=> $stable(cycle_time_o));
  a_r10_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ev_flags_o & ev_en_i) != '0);
endmodule

// File: tb/test_iso_cycle_clock.sv
module test_iso_cycle_clock;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 0, run_en_i = 0, init_i = 0, ct_wr_i = 0, bt_wr_i = 0;
  logic [31:0] init_secs_i = 0, ct_wdata_i = 0, bt_wdata_i = 0;
  logic [1:0]  ev_clr_i = 0, ev_en_i = 0;
  logic [31:0] cycle_time_o, bus_time_o;
  logic [1:0]  ev_flags_o;
  logic        irq_o;

  always #2 clk = ~clk;  // 250 MHz

  iso_cycle_clock i_iso_cycle_clock (
    .clk_i(clk), .rst_ni, .tick_i, .run_en_i, .init_i, .init_secs_i,
    .ct_wr_i, .ct_wdata_i, .bt_wr_i, .bt_wdata_i, .ev_clr_i, .ev_en_i,
    .cycle_time_o, .bus_time_o, .ev_flags_o, .irq_o);

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_ct = 0;
  logic [25:0] m_hi = 0;
  logic [1:0]  m_fl = 0;

  function automatic logic [25:0] f_adj(logic [25:0] hi, logic [31:0] ct);
    return (hi[0] != ct[31]) ? hi + 26'd1 : hi;
  endfunction

  function automatic logic [31:0] f_bt(logic [25:0] hi, logic [31:0] ct);
    return {f_adj(hi, ct), 6'b0} | {25'b0, ct[31:25]};
  endfunction

  function automatic logic [31:0] f_ct(logic [31:0] ct, logic adv, output logic wrap);
    logic [11:0] off = ct[11:0];
    logic [12:0] cnt = ct[24:12];
    logic [6:0]  sec = ct[31:25];
    wrap = 1'b0;
    if (adv) begin
      if (off >= 12'd3071) begin
        off = 0;
        if (cnt >= 13'd7999) begin
          cnt = 0;
          if (sec == 7'd127) begin sec = 0; wrap = 1'b1; end
          else sec = sec + 7'd1;
        end else cnt = cnt + 13'd1;
      end else off = off + 12'd1;
    end
    return {sec, cnt, off};
  endfunction

  task automatic check(string req);
    logic [31:0] e_bt = f_bt(m_hi, m_ct);
    logic        e_irq = |(m_fl & ev_en_i);
    n_run++;
    if (cycle_time_o !== m_ct || bus_time_o !== e_bt || ev_flags_o !== m_fl || irq_o !== e_irq) begin
      n_fail++;
      $display("FAIL %s: ct=%h exp %h bt=%h exp %h fl=%b exp %b irq=%b exp %b",
               req, cycle_time_o, m_ct, bus_time_o, e_bt, ev_flags_o, m_fl, irq_o, e_irq);
    end
  endtask

  // one clock: drive, model, edge, check
  task automatic cyc(input logic tk, input logic run, input logic cw, input logic [31:0] cwd,
                     input logic bw, input logic [31:0] bwd, input logic in, input logic [31:0] isec,
                     input logic [1:0] clr, input logic [1:0] en, input string req);
    logic [31:0] n_ct;
    logic [25:0] n_hi, adj;
    logic        wrap;
    logic [1:0]  set;
    tick_i = tk; run_en_i = run; ct_wr_i = cw; ct_wdata_i = cwd; bt_wr_i = bw;
    bt_wdata_i = bwd; init_i = in; init_secs_i = isec; ev_clr_i = clr; ev_en_i = en;
    n_ct = f_ct(m_ct, tk && run && !in && !cw, wrap);
    if (in) n_ct = {isec[6:0], 25'b0};
    else if (cw) n_ct = cwd;
    adj  = f_adj(m_hi, m_ct);
    n_hi = in ? isec[31:6] : (bw ? {bwd[31:7], adj[0]} : adj);
    set  = {cw && !in, wrap};
    @(posedge clk); #1;
    m_ct = n_ct; m_hi = n_hi;
    m_fl = (m_fl & ~clr) | set;
    tick_i = 0; ct_wr_i = 0; bt_wr_i = 0; init_i = 0; ev_clr_i = 0;
    check(req);
  endtask

  task automatic idle_tick(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, ev_en_i, req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, exp finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #7; check("R1 reset"); rst_ni = 1'b1;
    @(posedge clk); #1; check("R1 after release");

    // R2 counting and gating
    idle_tick(5, "R2 count");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 run_en low holds");
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 no tick holds");

    // R3 carries and out-of-range load
    cyc(0, 0, 1, {7'd5, 13'd7999, 12'd3070}, 0, 0, 0, 0, 2'b10, 0, "R3 load");
    idle_tick(2, "R3 cycle and second carry");
    cyc(0, 0, 1, {7'd9, 13'd8100, 12'd4000}, 0, 0, 0, 0, 0, 0, "R3 load out of range");
    idle_tick(2, "R3 out-of-range wrap");

    // R4 seconds wrap with R6 bus time carry, R10 masked then enabled
    cyc(0, 0, 1, {7'd127, 13'd7999, 12'd3071}, 0, 0, 0, 0, 2'b11, 2'b00, "R4 preload");
    idle_tick(1, "R4 seconds wrap R6 carry");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b01, "R10 enable irq");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'b01, 2'b01, "R9 clear wrap flag");

    // R5 write collides with tick at the last offset of the last cycle
    cyc(0, 0, 1, {7'd127, 13'd7999, 12'd3071}, 0, 0, 0, 0, 0, 2'b10, "R5 preload");
    cyc(1, 1, 1, 32'h1234_5678, 0, 0, 0, 0, 0, 2'b10, "R5 write beats tick");
    // R9 set and clear together
    cyc(0, 0, 1, 32'h0000_0100, 0, 0, 0, 0, 2'b10, 2'b10, "R9 set beats clear");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 2'b10, 2'b10, "R9 clear");

    // R8 init with collision, then R6 half-turn carries, R7 write
    cyc(0, 0, 1, 32'hFFFF_FFFF, 1, 32'hAAAA_AAAA, 1, 32'h89AB_CDEF, 0, 0, "R8 init beats writes");
    cyc(0, 0, 1, {7'd63, 13'd7999, 12'd3071}, 0, 0, 0, 0, 2'b10, 0, "R6 preload 63");
    idle_tick(2, "R6 msb rise carry");
    cyc(0, 0, 0, 0, 1, 32'h5555_5555, 0, 0, 0, 0, "R7 bus time write");
    cyc(0, 0, 1, {7'd10, 13'd0, 12'd0}, 0, 0, 0, 0, 0, 0, "R6 msb fall by load");
    cyc(0, 0, 0, 0, 1, 32'h0F0F_0F80, 0, 0, 0, 0, "R7 write during carry");

    // random mix
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      logic [31:0] v;
      if (r < 6) begin
        v = {7'($urandom), ($urandom_range(0,1) ? 13'd7999 : 13'($urandom_range(0,7999))),
             ($urandom_range(0,1) ? 12'(3070 + $urandom_range(0,1)) : 12'($urandom_range(0,3071)))};
        if (r == 0) v = $urandom;
        cyc(1'($urandom), 1, 1, v, 0, 0, 0, 0, 2'($urandom), 2'($urandom), "R5 random write");
      end else if (r < 9) begin
        cyc(1'($urandom), 1'($urandom), 0, 0, 1, $urandom, 0, 0, 0, ev_en_i, "R7 random bt write");
      end else if (r < 10) begin
        cyc(1, 1, 1'($urandom), $urandom, 1'($urandom), $urandom, 1, $urandom, 0, ev_en_i, "R8 random init");
      end else if (r < 15) begin
        cyc(1'($urandom), 1, 0, 0, 0, 0, 0, 0, 2'($urandom), 2'($urandom), "R9 R10 random clear");
      end else begin
        cyc(1'($urandom_range(0, 9) != 0), 1'($urandom_range(0, 19) != 0), 0, 0, 0, 0, 0, 0, 0,
            ev_en_i, "R2 R3 R4 R6 random run");
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule